// File: doc/BRIEF.md
# Grouped Descriptor Ring Address Generator

This block sits on the DMA side of a host interface. It turns a ring number and a descriptor index into the host memory address of that buffer descriptor, for seven transmit rings and two receive rings. The rings do not each carry a full base address. Software sets one 40-bit base per channel group, and each ring's configuration word holds two compact codes: a log2 size code and a start offset from its group base, counted in 512-byte steps.

Software programs the group bases and ring configuration words through a small synchronous register port. The DMA engine then sends requests that name a ring and a descriptor index. One cycle later it gets back the descriptor address and the ring's write and read pointers. The request can also advance either pointer, and the pointers wrap at the ring size. Illegal requests get an error response and change nothing. Writes that carry bits outside the defined fields set a sticky warning.

Top module: `grp_ring_addr_gen`

## Requirements
- R1: After reset, every group base, ring size code, offset, flag and pointer is zero. All register reads return 0, and `warn`, `reg_err`, `rsp_valid` and `rsp_err` are low.
- R2: Each group base occupies two register words: the low word holds address bits 31:3 in data bits 31:3, and the high word holds address bits 39:32 in data bits 7:0. The words are 0/1 for transmit group A, 2/3 for transmit group B and 4/5 for the receive group. Address bits 2:0 are always zero. A read returns its data on `reg_rdata` one cycle after `reg_re`.
- R3: Transmit channel c (0 to 15) has its configuration word at register address 16+c. It holds the size code in bits 2:0, a 9-bit offset in bits 12:4 and a flag in bit 14. Receive ring r has its word at address 32+r, with the size code in bits 2:0 and an 8-bit offset in bits 11:4. All other bits read as zero.
- R4: Size code 0 disables a ring (zero entries). Code n from 1 to 7 gives 2^(n+5) entries.
- R5: A request with `req_valid` high gives `rsp_valid` on the next cycle. On success, `rsp_addr` equals (group base + offset×512 + index×DESC_BYTES) mod 2^40. Transmit channels 0, 2, 4 and 6 use group A, channels 8, 10 and 12 use group B, and receive rings 0 and 1 use the receive group.
- R6: A successful request with `req_adv_wp` or `req_adv_rp` set advances that ring's pointer by one, modulo the ring size. `rsp_wp` and `rsp_rp` report the pointers after the request. A configuration write to a ring clears both of its pointers.
- R7: A request fails if it names an absent ring (an odd transmit channel, transmit channel 14, or a receive ring of 2 or more), a disabled ring, or an index at or above the ring size. A failed request gives `rsp_err`=1 with a zero address and zero pointers, and it changes no pointer.
- R8: A read or write to an unmapped address gives `reg_err`=1 on the next cycle and read data 0, and it changes no state. The unmapped addresses include 6 to 15, odd or absent transmit channel words, and receive words other than 32 and 33.
- R9: `warn` goes high after a mapped write with a nonzero bit outside its fields, and it stays high until reset. The offending bits are: bits 2:0 of a base low word, bits 31:8 of a base high word, any transmit configuration bit outside 14, 12:4 and 2:0, and any receive configuration bit outside 11:4 and 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the strobe |
| reg_err | output | 1 | Unmapped register access, one cycle after the strobe |
| req_valid | input | 1 | Address request strobe |
| req_rx | input | 1 | 1 selects a receive ring, 0 a transmit channel |
| req_chan | input | 4 | Channel or ring number |
| req_idx | input | 12 | Descriptor index |
| req_adv_wp | input | 1 | Advance the write pointer |
| req_adv_rp | input | 1 | Advance the read pointer |
| rsp_valid | output | 1 | Response valid |
| rsp_err | output | 1 | Request rejected |
| rsp_addr | output | ADDR_W | Descriptor address |
| rsp_wp | output | 12 | Write pointer after the request |
| rsp_rp | output | 12 | Read pointer after the request |
| warn | output | 1 | Sticky illegal-encoding warning |

## Verification
The bench places group A's base 8 bytes below the top of the 40-bit space. A design that lost the truncation, or added the offset at the wrong scale, would return addresses off by multiples of 512 or carry into a 41st bit. It tries every channel number in both directions, with indices at 0, size-1, size and 4095. An off-by-one size decode would accept index equal to size or reject size-1, and an odd channel that aliased onto its even neighbour would show up in the readback of every configuration word after the writes. Pointers are stepped past their wrap point on a 64-entry ring and a 2048-entry ring, and each sticky-warning cause is tested after its own reset, so a missed reserved bit shows up as `warn` staying low.

// File: rtl/grp_ring_addr_gen.sv
module grp_ring_addr_gen #(
  parameter int ADDR_W       = 40,
  parameter int DESC_BYTES   = 16,
  parameter int TX_RINGS     = 7,
  parameter int RX_RINGS     = 2,
  parameter int TX_GRP_SPLIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_err,
  input  logic              req_valid,
  input  logic              req_rx,
  input  logic [3:0]        req_chan,
  input  logic [11:0]       req_idx,
  input  logic              req_adv_wp,
  input  logic              req_adv_rp,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [11:0]       rsp_wp,
  output logic [11:0]       rsp_rp,
  output logic              warn
);
  localparam int HI_W  = ADDR_W - 32;
  localparam int NR    = TX_RINGS + RX_RINGS;
  localparam int RW    = $clog2(NR);
  localparam int IDX_W = 12;
  localparam int SZ_W  = IDX_W + 1;
  localparam logic [31:0] TX_KEEP = 32'h0000_5FF7;
  localparam logic [31:0] RX_KEEP = 32'h0000_0FF7;
  localparam logic [31:0] HI_KEEP = 32'((64'd1 << HI_W) - 64'd1);

  function automatic logic [SZ_W-1:0] ring_size(input logic [2:0] code);
    ring_size = (code == 3'd0) ? '0 : SZ_W'(1) << (32'(code) + 5);
  endfunction

  logic [ADDR_W-1:0]          base_q [3];
  logic [2:0]                 sz_q   [NR];
  logic [8:0]                 off_q  [NR];
  logic [NR-1:0]              flag_q;
  logic [NR-1:0][IDX_W-1:0]   wp_q, rp_q;

  // register port decode
  logic          acc, a_base, a_tx, a_rx, a_hit, bad_wr;
  logic [1:0]    a_grp;
  logic [RW-1:0] a_ring;
  logic [31:0]   rd_val;

  assign acc    = reg_we | reg_re;
  assign a_base = reg_addr < 6'd6;
  assign a_grp  = reg_addr[2:1];
  assign a_tx   = reg_addr[5:4] == 2'b01 && !reg_addr[0] && 32'(reg_addr[3:1]) < TX_RINGS;
  assign a_rx   = reg_addr[5:4] == 2'b10 && 32'(reg_addr[3:0]) < RX_RINGS;
  assign a_hit  = a_base | a_tx | a_rx;
  assign a_ring = a_tx ? RW'(reg_addr[3:1]) :
                  a_rx ? RW'(TX_RINGS + 32'(reg_addr[3:0])) : '0;

  always_comb begin
    rd_val = '0;
    bad_wr = 1'b0;
    if (a_base && !reg_addr[0]) begin
      rd_val = {base_q[a_grp][31:3], 3'b000};
      bad_wr = |reg_wdata[2:0];
    end else if (a_base) begin
      rd_val = 32'(base_q[a_grp][ADDR_W-1:32]);
      bad_wr = |(reg_wdata & ~HI_KEEP);
    end else if (a_tx) begin
      rd_val = 32'({flag_q[a_ring], 1'b0, off_q[a_ring], 1'b0, sz_q[a_ring]});
      bad_wr = |(reg_wdata & ~TX_KEEP);
    end else if (a_rx) begin
      rd_val = 32'({off_q[a_ring][7:0], 1'b0, sz_q[a_ring]});
      bad_wr = |(reg_wdata & ~RX_KEEP);
    end
  end

  // request decode
  logic              q_ok, q_err;
  logic [RW-1:0]     q_ring;
  logic [1:0]        q_grp;
  logic [SZ_W-1:0]   q_size;
  logic [IDX_W-1:0]  q_mask, q_wp_nx, q_rp_nx;
  logic [ADDR_W-1:0] q_addr;

  assign q_ok    = req_rx ? 32'(req_chan) < RX_RINGS
                          : (!req_chan[0] && 32'(req_chan[3:1]) < TX_RINGS);
  assign q_ring  = !q_ok  ? '0 :
                   req_rx ? RW'(TX_RINGS + 32'(req_chan)) : RW'(req_chan[3:1]);
  assign q_grp   = req_rx ? 2'd2 : (32'(req_chan[3:1]) < TX_GRP_SPLIT) ? 2'd0 : 2'd1;
  assign q_size  = ring_size(sz_q[q_ring]);
  assign q_mask  = IDX_W'(q_size - SZ_W'(1));
  assign q_err   = !q_ok || q_size == '0 || {1'b0, req_idx} >= q_size;
  assign q_addr  = base_q[q_grp] + (ADDR_W'(off_q[q_ring]) << 9)
                 + ADDR_W'(req_idx) * ADDR_W'(DESC_BYTES);
  assign q_wp_nx = req_adv_wp ? (wp_q[q_ring] + 1'b1) & q_mask : wp_q[q_ring];
  assign q_rp_nx = req_adv_rp ? (rp_q[q_ring] + 1'b1) & q_mask : rp_q[q_ring];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < 3; g++) base_q[g] <= '0;
      for (int r = 0; r < NR; r++) begin
        sz_q[r]  <= '0;
        off_q[r] <= '0;
      end
      flag_q    <= '0;
      wp_q      <= '0;
      rp_q      <= '0;
      warn      <= 1'b0;
      reg_rdata <= '0;
      reg_err   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_addr  <= '0;
      rsp_wp    <= '0;
      rsp_rp    <= '0;
    end else begin
      reg_rdata <= (reg_re && a_hit) ? rd_val : '0;
      reg_err   <= acc && !a_hit;
      warn      <= warn | (reg_we & a_hit & bad_wr);
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && q_err;
      rsp_addr  <= (req_valid && !q_err) ? q_addr  : '0;
      rsp_wp    <= (req_valid && !q_err) ? q_wp_nx : '0;
      rsp_rp    <= (req_valid && !q_err) ? q_rp_nx : '0;
      if (req_valid && !q_err) begin
        wp_q[q_ring] <= q_wp_nx;
        rp_q[q_ring] <= q_rp_nx;
      end
      if (reg_we && a_base && !reg_addr[0]) base_q[a_grp][31:3] <= reg_wdata[31:3];
      if (reg_we && a_base && reg_addr[0])  base_q[a_grp][ADDR_W-1:32] <= reg_wdata[HI_W-1:0];
      if (reg_we && (a_tx || a_rx)) begin
        sz_q[a_ring]  <= reg_wdata[2:0];
        off_q[a_ring] <= a_tx ? reg_wdata[12:4] : {1'b0, reg_wdata[11:4]};
        wp_q[a_ring]  <= '0;
        rp_q[a_ring]  <= '0;
      end
      if (reg_we && a_tx) flag_q[a_ring] <= reg_wdata[14];
    end
  end

  // R9
  warn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) warn |=> warn);

  // R5
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R8
  reg_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_err |-> $past(acc));

  // R7
  err_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_err && !$past(reg_we)) |-> ($stable(wp_q) && $stable(rp_q)));

  for (genvar i = 0; i < NR; i++) begin : g_bound
    // R6
    ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SZ_W'(wp_q[i]) < ring_size(sz_q[i]) && SZ_W'(rp_q[i]) < ring_size(sz_q[i]))
      || (sz_q[i] == 3'd0 && wp_q[i] == '0 && rp_q[i] == '0));
  end
endmodule

// File: tb/grp_ring_addr_gen_test.sv
`timescale 1ns/1ps
module grp_ring_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_err;
  logic        req_valid = 1'b0, req_rx = 1'b0, req_adv_wp = 1'b0, req_adv_rp = 1'b0;
  logic [3:0]  req_chan = '0;
  logic [11:0] req_idx = '0;
  logic        rsp_valid, rsp_err, warn;
  logic [39:0] rsp_addr;
  logic [11:0] rsp_wp, rsp_rp;

  grp_ring_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .req_valid(req_valid), .req_rx(req_rx), .req_chan(req_chan), .req_idx(req_idx),
    .req_adv_wp(req_adv_wp), .req_adv_rp(req_adv_rp), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_addr(rsp_addr), .rsp_wp(rsp_wp), .rsp_rp(rsp_rp), .warn(warn)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [39:0] bbase [3];
  int bsz [9], boff [9], bwp [9], brp [9];
  bit bflag [9];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bsize(input int code);
    return code == 0 ? 0 : (1 << (code + 5));
  endfunction

  function automatic bit hit(input int a);
    return a < 6 || (a >= 16 && a < 32 && a % 2 == 0 && (a - 16) / 2 < 7) || a == 32 || a == 33;
  endfunction

  function automatic logic [31:0] exp_rd(input int a);
    int r;
    if (a < 6) return (a % 2 == 0) ? {bbase[a/2][31:3], 3'b000} : {24'b0, bbase[a/2][39:32]};
    if (a >= 16 && a < 32 && hit(a)) begin
      r = (a - 16) / 2;
      return {17'b0, bflag[r], 1'b0, 9'(boff[r]), 1'b0, 3'(bsz[r])};
    end
    if (a == 32 || a == 33) begin
      r = 7 + a - 32;
      return {20'b0, 8'(boff[r]), 1'b0, 3'(bsz[r])};
    end
    return '0;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    for (int g = 0; g < 3; g++) bbase[g] = '0;
    for (int r = 0; r < 9; r++) begin
      bsz[r] = 0; boff[r] = 0; bwp[r] = 0; brp[r] = 0; bflag[r] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d, output logic e);
    reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk);
    e = reg_err;
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d, output logic e);
    reg_re = 1'b1; reg_addr = 6'(a);
    @(negedge clk);
    d = reg_rdata; e = reg_err;
    reg_re = 1'b0;
  endtask

  task automatic wr_cfg_model(input int a, input logic [31:0] d);
    int r;
    if (a < 6) begin
      if (a % 2 == 0) bbase[a/2][31:3] = d[31:3];
      else bbase[a/2][39:32] = d[7:0];
    end else if (a >= 16 && a < 32 && hit(a)) begin
      r = (a - 16) / 2;
      bsz[r] = int'(d[2:0]); boff[r] = int'(d[12:4]); bflag[r] = d[14];
      bwp[r] = 0; brp[r] = 0;
    end else if (a == 32 || a == 33) begin
      r = 7 + a - 32;
      bsz[r] = int'(d[2:0]); boff[r] = int'(d[11:4]);
      bwp[r] = 0; brp[r] = 0;
    end
  endtask

  task automatic sweep_rd(input string tag);
    logic [31:0] d;
    logic e;
    for (int a = 0; a < 64; a++) begin
      rd(a, d, e);
      chk({tag, " rdata"}, 64'(d), 64'(exp_rd(a)));
      chk("R8 reg_err on read", 64'(e), 64'(!hit(a)));
    end
  endtask

  task automatic do_req(input string tag, input bit rx, input int ch, input int idx,
                        input bit awp, input bit arp);
    bit ok, er;
    int r, g, sz;
    logic [63:0] t;
    logic [39:0] ea;
    ok = rx ? (ch < 2) : (ch % 2 == 0 && ch / 2 < 7);
    r  = !ok ? 0 : (rx ? 7 + ch : ch / 2);
    g  = rx ? 2 : (ch / 2 < 4 ? 0 : 1);
    sz = bsize(bsz[r]);
    er = !ok || sz == 0 || idx >= sz;
    t  = 64'(bbase[g]) + 64'(boff[r]) * 64'd512 + 64'(idx) * 64'd16;
    ea = er ? 40'd0 : t[39:0];
    if (!er) begin
      if (awp) bwp[r] = (bwp[r] + 1) % sz;
      if (arp) brp[r] = (brp[r] + 1) % sz;
    end
    req_valid = 1'b1; req_rx = rx; req_chan = 4'(ch); req_idx = 12'(idx);
    req_adv_wp = awp; req_adv_rp = arp;
    @(negedge clk);
    req_valid = 1'b0; req_adv_wp = 1'b0; req_adv_rp = 1'b0;
    chk("R5 rsp_valid", 64'(rsp_valid), 64'd1);
    chk({tag, " err"}, 64'(rsp_err), 64'(er));
    chk({tag, " addr"}, 64'(rsp_addr), 64'(ea));
    chk({tag, " wp"}, 64'(rsp_wp), er ? 64'd0 : 64'(bwp[r]));
    chk({tag, " rp"}, 64'(rsp_rp), er ? 64'd0 : 64'(brp[r]));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic e;
    logic [31:0] d;
    int idxs [9] = '{0, 1, 63, 64, 127, 128, 2047, 2048, 4095};

    // R1: reset state
    do_reset();
    chk("R1 warn", 64'(warn), 64'd0);
    chk("R1 reg_err", 64'(reg_err), 64'd0);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 rsp_err", 64'(rsp_err), 64'd0);
    sweep_rd("R1 reset readback");

    // R2: group bases
    wr(0, 32'hFFFF_FFF8, e); wr_cfg_model(0, 32'hFFFF_FFF8); chk("R2 wr err", 64'(e), 0);
    wr(1, 32'h0000_00FF, e); wr_cfg_model(1, 32'h0000_00FF); chk("R2 wr err", 64'(e), 0);
    wr(2, 32'h1234_5670, e); wr_cfg_model(2, 32'h1234_5670); chk("R2 wr err", 64'(e), 0);
    wr(3, 32'h0000_0001, e); wr_cfg_model(3, 32'h0000_0001); chk("R2 wr err", 64'(e), 0);
    wr(4, 32'h0000_1000, e); wr_cfg_model(4, 32'h0000_1000); chk("R2 wr err", 64'(e), 0);
    wr(5, 32'h0000_0080, e); wr_cfg_model(5, 32'h0000_0080); chk("R2 wr err", 64'(e), 0);

    // R3, R8: configuration words; odd/absent channel writes must error and not alias
    for (int c = 0; c < 16; c++) begin
      d = {17'b0, 1'(c >> 1), 1'b0, 9'((c * 37 + 5) % 512), 1'b0, 3'((c / 2) % 8)};
      wr(16 + c, d, e);
      wr_cfg_model(16 + c, d);
      chk("R8 tx cfg write err", 64'(e), 64'(!hit(16 + c)));
    end
    wr(32, {20'b0, 8'hFF, 1'b0, 3'd7}, e); wr_cfg_model(32, {20'b0, 8'hFF, 1'b0, 3'd7});
    chk("R3 rx0 write err", 64'(e), 0);
    wr(33, {20'b0, 8'h03, 1'b0, 3'd1}, e); wr_cfg_model(33, {20'b0, 8'h03, 1'b0, 3'd1});
    chk("R3 rx1 write err", 64'(e), 0);
    for (int a = 6; a < 16; a++) begin
      wr(a, 32'h0000_0011, e);
      chk("R8 unmapped write err", 64'(e), 64'd1);
    end
    for (int a = 34; a < 64; a++) begin
      wr(a, 32'h0000_0022, e);
      chk("R8 unmapped write err", 64'(e), 64'd1);
    end
    sweep_rd("R3 config readback");
    chk("R9 legal writes leave warn low", 64'(warn), 64'd0);

    // R4, R5, R7: address sweep over every channel and boundary indices
    for (int rx = 0; rx < 2; rx++)
      for (int ch = 0; ch < 16; ch++)
        for (int k = 0; k < 9; k++)
          do_req("R5 R4 R7 addr sweep", bit'(rx), ch, idxs[k], 1'b0, 1'b0);
    @(negedge clk);
    chk("R5 idle rsp_valid", 64'(rsp_valid), 64'd0);

    // R6: pointer wrap on 64-entry ring (tx ch 2) and 2048-entry ring (tx ch 12)
    for (int k = 0; k < 130; k++) do_req("R6 wp wrap ch2", 1'b0, 2, 5, 1'b1, 1'b0);
    for (int k = 0; k < 70; k++)  do_req("R6 rp wrap ch2", 1'b0, 2, 0, 1'b0, 1'b1);
    for (int k = 0; k < 10; k++)  do_req("R6 both ch2", 1'b0, 2, 63, 1'b1, 1'b1);
    for (int k = 0; k < 66; k++)  do_req("R6 wp wrap rx1", 1'b1, 1, 1, 1'b1, 1'b0);
    for (int k = 0; k < 2050; k++) do_req("R6 wp wrap ch12", 1'b0, 12, 7, 1'b1, 1'b0);

    // R7: failed requests change no pointer
    do_req("R7 odd ch", 1'b0, 3, 0, 1'b1, 1'b1);
    do_req("R7 odd ch", 1'b0, 13, 0, 1'b1, 1'b1);
    do_req("R7 absent ch14", 1'b0, 14, 0, 1'b1, 1'b1);
    do_req("R7 absent ch15", 1'b0, 15, 0, 1'b1, 1'b1);
    do_req("R7 absent rx2", 1'b1, 2, 0, 1'b1, 1'b1);
    do_req("R7 disabled ch0", 1'b0, 0, 0, 1'b1, 1'b1);
    do_req("R7 idx at size", 1'b0, 2, 64, 1'b1, 1'b1);
    do_req("R7 ch2 unchanged", 1'b0, 2, 0, 1'b0, 1'b0);
    do_req("R7 ch12 unchanged", 1'b0, 12, 0, 1'b0, 1'b0);

    // R6: configuration write clears pointers
    d = {17'b0, 1'b1, 1'b0, 9'd79, 1'b0, 3'd1};
    wr(18, d, e); wr_cfg_model(18, d);
    do_req("R6 cfg write clears ptr", 1'b0, 2, 0, 1'b0, 1'b0);
    do_req("R6 after clear", 1'b0, 2, 0, 1'b1, 1'b1);

    // R9: each warning cause on its own reset
    do_reset();
    wr(0, 32'h1000_0005, e); wr_cfg_model(0, 32'h1000_0005);
    chk("R9 misaligned base warn", 64'(warn), 64'd1);
    rd(0, d, e);
    chk("R2 low bits dropped", 64'(d), 64'h1000_0000);
    wr(2, 32'h0000_0100, e);
    chk("R9 warn sticky", 64'(warn), 64'd1);
    do_reset();
    chk("R1 warn cleared by reset", 64'(warn), 64'd0);
    wr(20, 32'h0000_5FF7, e);
    chk("R9 full legal tx cfg no warn", 64'(warn), 64'd0);
    wr(20, 32'h0000_0019, e); wr_cfg_model(20, 32'h0000_0019);
    chk("R9 tx bit3 warn", 64'(warn), 64'd1);
    rd(20, d, e);
    chk("R3 reserved bit not stored", 64'(d), 64'(exp_rd(20)));
    do_reset();
    wr(16, 32'h0000_2001, e);
    chk("R9 tx bit13 warn", 64'(warn), 64'd1);
    do_reset();
    wr(32, 32'h0000_0FF7, e);
    chk("R9 full legal rx cfg no warn", 64'(warn), 64'd0);
    wr(33, 32'h0000_1001, e);
    chk("R9 rx bit12 warn", 64'(warn), 64'd1);
    do_reset();
    wr(5, 32'h0000_0180, e);
    chk("R9 base high bit8 warn", 64'(warn), 64'd1);
    do_reset();
    wr(40, 32'hFFFF_FFFF, e);
    chk("R8 unmapped write no warn", 64'(warn), 64'd0);
    chk("R8 unmapped write err", 64'(e), 64'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule